// File: doc/BRIEF.md
# EPP Host Cycle Controller

This block sits between a simple host register bus and the pins of a printer port, and adds enhanced-parallel-port address and data transfers. The host reads and writes three plain registers (data latch, status, control). It also reaches two transfer windows: offset 3 for address transfers and offset 4 for data transfers. A transfer window runs a strobe/wait handshake with the peripheral only when the control register holds the exact bit pattern that the transfer direction needs. Otherwise the access completes at once and has no effect on the pins.

Each handshake runs under a cycle budget. If the peripheral's wait line does not answer in time, the transfer is abandoned and the strobes are released. A sticky timeout flag is then set; it appears in status bit 0 and is cleared by writing a one there. The data window accepts 1-, 2- or 4-byte host accesses and splits them into single-byte handshakes, least significant byte first. While a transfer is in flight, `ready` is low and further requests are held off.

Top module: `epp_host_ctrl`

## Requirements
- R1: After reset the control register reads 0xCC, the data register reads 0xFF, status bit 0 reads 0, `ready` is high, `pd_oe` is high, and `n_write`, `n_astrb` and `n_dstrb` are high.
- R2: A write to offset 3 or 4 starts a handshake only when (control AND 0x2F) equals 0x04. Otherwise no strobe falls, nothing is sent, and `done` follows the accept by one cycle.
- R3: A read of offset 3 or 4 starts a handshake only when (control AND 0x2F) equals 0x24. Otherwise it returns all ones over the access width (size 0: 0xFF, size 1: 0xFFFF, size 2: 0xFFFFFFFF) and no strobe falls.
- R4: A write handshake drives `n_write` low with the byte on `pd_out`, then lowers the strobe (`n_astrb` for offset 3, `n_dstrb` for offset 4). It raises the strobe once `n_wait` is seen high, then waits for `n_wait` low.
- R5: A read handshake keeps `n_write` high and captures `pd_in` in the cycle in which `n_wait` is seen high while the strobe is low.
- R6: If `n_wait` does not answer within TIMEOUT_CYCLES cycles in either wait phase, the transfer aborts: the strobe rises, the timeout flag sets, and `done` pulses.
- R7: A status read (offset 1) returns `stat_in[7:1]` with the timeout flag in bit 0. A status write with bit 0 set clears the flag; with bit 0 clear it leaves the flag unchanged.
- R8: On offset 4, `size` 0, 1 and 2 move 1, 2 and 4 bytes. Byte k travels in handshake k, from bits 8k+7:8k. Offset 3 always moves one byte.
- R9: A write of the data (offset 0) or control (offset 2) register pulses `pin_load` for one cycle only if the stored value changes. Control bits 7:6 always read as 1.
- R10: Control bit 5 selects the bus direction: `pd_oe` equals the inverse of bit 5. With bit 5 set, a data-register read returns `pd_in`; with it clear, the read returns the stored data byte.
- R11: `ready` is low from the cycle after an accepted request until `done` has pulsed. `done` lasts one cycle.
- R12: At most one strobe is low at a time, and a strobe is low only while the control pattern is 0x04 or 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host access request, taken when `ready` is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register offset |
| size | input | 2 | Access width on offset 4: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| wdata | input | BUS_W | Host write data |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle completion pulse; `rdata` valid |
| rdata | output | BUS_W | Host read data |
| stat_in | input | 8 | Peripheral status lines |
| ctrl_out | output | 8 | Stored control register value |
| pd_in | input | 8 | Data bus from the peripheral |
| pd_out | output | 8 | Data bus to the peripheral |
| pd_oe | output | 1 | Data bus output enable |
| pin_load | output | 1 | Pulse when data or control pins change |
| n_write | output | 1 | Transfer direction, low for writes |
| n_astrb | output | 1 | Address strobe, active low |
| n_dstrb | output | 1 | Data strobe, active low |
| n_wait | input | 1 | Peripheral wait/acknowledge |

## Verification
The bench targets the gating patterns that differ by one bit between reads and writes. A design that confused them would strobe with the bus facing the wrong way, or would return real data where all ones are due. It checks the byte order of wide reads and writes against a peripheral model; a reversed lane index shows up as swapped bytes. It starves the wait line to force the budget to expire, which catches a controller that hangs or forgets the flag. It then writes status with bit 0 clear and then set, which catches a flag that clears on any write. Repeated equal writes must leave `pin_load` quiet, which catches missing skip logic.

// File: rtl/epp_pkg.sv
package epp_pkg;
   localparam logic [2:0] OFS_DATA  = 3'd0;
   localparam logic [2:0] OFS_STAT  = 3'd1;
   localparam logic [2:0] OFS_CTRL  = 3'd2;
   localparam logic [2:0] OFS_EADDR = 3'd3;
   localparam logic [2:0] OFS_EDATA = 3'd4;

   localparam logic [7:0] MODE_MASK = 8'h2F;
   localparam logic [7:0] MODE_WR   = 8'h04;
   localparam logic [7:0] MODE_RD   = 8'h24;
   localparam logic [7:0] CTRL_RST  = 8'hCC;
   localparam logic [7:0] CTRL_FIX  = 8'hC0;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STRB,
      ST_REL,
      ST_FIN
   } epp_st_e;
endpackage

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run || clr) cnt <= '0;
      else if (!expired)         cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/epp_port_regs.sv
module epp_port_regs
   import epp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_byte,
   input  logic       set_to,
   input  logic [2:0] rd_addr,
   input  logic [7:0] stat_in,
   input  logic [7:0] pd_in,
   output logic [7:0] ctrl_q,
   output logic [7:0] data_q,
   output logic       to_flag,
   output logic       pin_load,
   output logic [7:0] rd_byte
);
   logic [7:0] ctrl_nx;
   assign ctrl_nx = wr_byte | CTRL_FIX;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= CTRL_RST;
         data_q   <= 8'hFF;
         to_flag  <= 1'b0;
         pin_load <= 1'b0;
      end else begin
         pin_load <= 1'b0;
         if (set_to) to_flag <= 1'b1;
         if (wr_en) begin
            case (wr_addr)
               OFS_DATA: if (wr_byte != data_q) begin
                  data_q   <= wr_byte;
                  pin_load <= 1'b1;
               end
               OFS_STAT: if (wr_byte[0]) to_flag <= 1'b0;
               OFS_CTRL: if (ctrl_nx != ctrl_q) begin
                  ctrl_q   <= ctrl_nx;
                  pin_load <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (rd_addr)
         OFS_DATA: rd_byte = ctrl_q[5] ? pd_in : data_q;
         OFS_STAT: rd_byte = {stat_in[7:1], to_flag};
         OFS_CTRL: rd_byte = ctrl_q;
         default:  rd_byte = 8'hFF;
      endcase
   end
endmodule

// File: rtl/epp_cycle_seq.sv
module epp_cycle_seq
   import epp_pkg::*;
#(
   parameter int BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic             acc_we,
   input  logic [2:0]       acc_addr,
   input  logic [1:0]       acc_size,
   input  logic [BUS_W-1:0] acc_wdata,
   input  logic [7:0]       ctrl,
   input  logic [7:0]       reg_rdata,
   input  logic             n_wait,
   input  logic [7:0]       pd_in,
   input  logic             expired,
   output logic             timer_run,
   output logic             timer_clr,
   output logic             ready,
   output logic             done,
   output logic [BUS_W-1:0] rdata,
   output logic             n_write,
   output logic             n_astrb,
   output logic             n_dstrb,
   output logic             cyc_wr,
   output logic [7:0]       cyc_byte,
   output logic             set_to
);
   localparam int NBYTE = BUS_W / 8;
   localparam int IW    = (NBYTE > 1) ? $clog2(NBYTE) : 1;

   epp_st_e          st;
   logic             we_q, is_addr;
   logic [IW-1:0]    bidx, last;
   logic [BUS_W-1:0] wbuf;
   logic             is_epp, mode_ok;
   logic [IW-1:0]    nb_m1;
   logic [BUS_W-1:0] ones_w;

   assign is_epp  = (acc_addr == OFS_EADDR) || (acc_addr == OFS_EDATA);
   assign mode_ok = (ctrl & MODE_MASK) == (acc_we ? MODE_WR : MODE_RD);

   always_comb begin
      nb_m1 = '0;
      if (acc_addr == OFS_EDATA)
         nb_m1 = IW'(((1 << acc_size) > NBYTE ? NBYTE : (1 << acc_size)) - 1);
   end

   generate
      for (genvar g = 0; g < NBYTE; g++) begin : g_mask
         assign ones_w[8*g +: 8] = (g <= int'(nb_m1)) ? 8'hFF : 8'h00;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         we_q    <= 1'b0;
         is_addr <= 1'b0;
         bidx    <= '0;
         last    <= '0;
         wbuf    <= '0;
         rdata   <= '0;
      end else begin
         case (st)
            ST_IDLE: if (acc) begin
               we_q    <= acc_we;
               is_addr <= (acc_addr == OFS_EADDR);
               bidx    <= '0;
               last    <= nb_m1;
               wbuf    <= acc_wdata;
               if (is_epp && mode_ok) begin
                  st    <= ST_SETUP;
                  rdata <= ones_w;
               end else begin
                  st    <= ST_FIN;
                  rdata <= is_epp ? ones_w : BUS_W'(reg_rdata);
               end
            end
            ST_SETUP: st <= ST_STRB;
            ST_STRB: begin
               if (n_wait) begin
                  if (!we_q) rdata[8*bidx +: 8] <= pd_in;
                  st <= ST_REL;
               end else if (expired) st <= ST_FIN;
            end
            ST_REL: begin
               if (!n_wait) begin
                  if (bidx == last) st <= ST_FIN;
                  else begin
                     bidx <= bidx + 1'b1;
                     st   <= ST_SETUP;
                  end
               end else if (expired) st <= ST_FIN;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   logic in_cyc;
   assign in_cyc    = (st == ST_SETUP) || (st == ST_STRB) || (st == ST_REL);
   assign timer_run = (st == ST_STRB) || (st == ST_REL);
   assign timer_clr = (st == ST_STRB) && n_wait;
   assign set_to    = ((st == ST_STRB) && !n_wait && expired) ||
                      ((st == ST_REL) && n_wait && expired);
   assign ready     = (st == ST_IDLE);
   assign done      = (st == ST_FIN);
   assign cyc_wr    = in_cyc && we_q;
   assign n_write   = !cyc_wr;
   assign n_astrb   = !((st == ST_STRB) && is_addr);
   assign n_dstrb   = !((st == ST_STRB) && !is_addr);
   assign cyc_byte  = wbuf[8*bidx +: 8];
endmodule

// File: rtl/epp_host_ctrl.sv
module epp_host_ctrl
   import epp_pkg::*;
#(
   parameter int BUS_W          = 32,
   parameter int TIMEOUT_CYCLES = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             we,
   input  logic [2:0]       addr,
   input  logic [1:0]       size,
   input  logic [BUS_W-1:0] wdata,
   output logic             ready,
   output logic             done,
   output logic [BUS_W-1:0] rdata,
   input  logic [7:0]       stat_in,
   output logic [7:0]       ctrl_out,
   input  logic [7:0]       pd_in,
   output logic [7:0]       pd_out,
   output logic             pd_oe,
   output logic             pin_load,
   output logic             n_write,
   output logic             n_astrb,
   output logic             n_dstrb,
   input  logic             n_wait
);
   generate
      if (BUS_W != 8 && BUS_W != 16 && BUS_W != 32) begin : g_bad_w
         $error("BUS_W must be 8, 16 or 32");
      end
      if (TIMEOUT_CYCLES < 2) begin : g_bad_t
         $error("TIMEOUT_CYCLES must be at least 2");
      end
   endgenerate

   logic       acc, set_to, expired, t_run, t_clr, cyc_wr, to_flag;
   logic [7:0] data_q, reg_rdata, cyc_byte;

   assign acc = req && ready;

   epp_port_regs regs_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(acc && we && (addr < OFS_EADDR)),
      .wr_addr(addr), .wr_byte(wdata[7:0]), .set_to(set_to),
      .rd_addr(addr), .stat_in(stat_in), .pd_in(pd_in),
      .ctrl_q(ctrl_out), .data_q(data_q), .to_flag(to_flag),
      .pin_load(pin_load), .rd_byte(reg_rdata)
   );

   epp_cycle_seq #(.BUS_W(BUS_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .acc(acc), .acc_we(we),
      .acc_addr(addr), .acc_size(size), .acc_wdata(wdata),
      .ctrl(ctrl_out), .reg_rdata(reg_rdata), .n_wait(n_wait),
      .pd_in(pd_in), .expired(expired), .timer_run(t_run),
      .timer_clr(t_clr), .ready(ready), .done(done), .rdata(rdata),
      .n_write(n_write), .n_astrb(n_astrb), .n_dstrb(n_dstrb),
      .cyc_wr(cyc_wr), .cyc_byte(cyc_byte), .set_to(set_to)
   );

   epp_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) tmr_i (
      .clk(clk), .rst_n(rst_n), .run(t_run), .clr(t_clr),
      .expired(expired)
   );

   assign pd_out = cyc_wr ? cyc_byte : data_q;
   assign pd_oe  = !ctrl_out[5];
endmodule

// File: rtl/epp_host_ctrl_chk.sv
module epp_host_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req,
   input logic       ready,
   input logic       done,
   input logic [7:0] ctrl_out,
   input logic       pd_oe,
   input logic       n_write,
   input logic       n_astrb,
   input logic       n_dstrb
);
   logic strb;
   assign strb = !n_astrb || !n_dstrb;

   // R12
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!n_astrb && !n_dstrb));
   // R12
   strobe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb |-> (((ctrl_out & 8'h2F) == 8'h04) || ((ctrl_out & 8'h2F) == 8'h24)));
   // R4
   bus_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb |-> (pd_oe == !n_write));
   // R11
   busy_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready) |=> !ready);
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R11
   strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb |-> !ready);
   // R9
   ctrl_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_out[7:6] == 2'b11);
endmodule

bind epp_host_ctrl epp_host_ctrl_chk chk_i (
   .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .done(done),
   .ctrl_out(ctrl_out), .pd_oe(pd_oe), .n_write(n_write),
   .n_astrb(n_astrb), .n_dstrb(n_dstrb)
);

// File: tb/epp_host_ctrl_tb_top.sv
module epp_host_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TMO = 20;

   logic        clk = 0, rst_n = 0, req = 0, we = 0;
   logic [2:0]  addr = 0;
   logic [1:0]  size = 0;
   logic [31:0] wdata = 0, rdata;
   logic        ready, done, pd_oe, pin_load, n_write, n_astrb, n_dstrb;
   logic [7:0]  stat_in = 8'h5B, ctrl_out, pd_out;
   logic [7:0]  pd_in = 8'h77;
   logic        n_wait = 0;

   int errors = 0, checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   epp_host_ctrl #(.BUS_W(32), .TIMEOUT_CYCLES(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
      .size(size), .wdata(wdata), .ready(ready), .done(done),
      .rdata(rdata), .stat_in(stat_in), .ctrl_out(ctrl_out),
      .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
      .pin_load(pin_load), .n_write(n_write), .n_astrb(n_astrb),
      .n_dstrb(n_dstrb), .n_wait(n_wait)
   );

   // peripheral model
   logic       resp_en = 1;
   int         dly = 0, rd_cnt = 0, log_n = 0, loads = 0;
   logic [8:0] wlog [8];

   always @(posedge clk) begin
      if (pin_load) loads <= loads + 1;
      if ((!n_astrb || !n_dstrb) && !n_wait && resp_en) begin
         if (dly == 1) begin
            n_wait <= 1;
            if (n_write) begin
               pd_in  <= 8'hA0 + 8'(rd_cnt);
               rd_cnt <= rd_cnt + 1;
            end else if (log_n < 8) begin
               wlog[log_n] <= {!n_astrb, pd_out};
               log_n <= log_n + 1;
            end
         end else dly <= dly + 1;
      end else if (n_astrb && n_dstrb && n_wait) begin
         n_wait <= 0;
         pd_in  <= 8'h77;
         dly    <= 0;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic host(input logic w, input logic [2:0] a, input logic [1:0] s,
                       input logic [31:0] d, output logic [31:0] r, output int n);
      @(negedge clk);
      req = 1; we = w; addr = a; size = s; wdata = d;
      @(negedge clk);
      req = 0;
      n = 1;
      while (!done) begin
         @(negedge clk);
         n++;
      end
      r = rdata;
      @(negedge clk);
   endtask

   // {chk, we, addr, size, wdata, expected}
   localparam logic [70:0] VEC [12] = '{
      {1'b1, 1'b0, 3'd2, 2'd0, 32'h0,    32'h000000CC},
      {1'b1, 1'b0, 3'd0, 2'd0, 32'h0,    32'h000000FF},
      {1'b1, 1'b0, 3'd1, 2'd0, 32'h0,    32'h0000005A},
      {1'b0, 1'b1, 3'd2, 2'd0, 32'h04,   32'h0},
      {1'b1, 1'b0, 3'd2, 2'd0, 32'h0,    32'h000000C4},
      {1'b0, 1'b1, 3'd3, 2'd0, 32'h3C,   32'h0},
      {1'b0, 1'b1, 3'd4, 2'd1, 32'hBEEF, 32'h0},
      {1'b1, 1'b0, 3'd4, 2'd1, 32'h0,    32'h0000FFFF},
      {1'b0, 1'b1, 3'd2, 2'd0, 32'h24,   32'h0},
      {1'b1, 1'b0, 3'd4, 2'd1, 32'h0,    32'h0000A1A0},
      {1'b0, 1'b1, 3'd4, 2'd0, 32'h11,   32'h0},
      {1'b1, 1'b0, 3'd2, 2'd0, 32'h0,    32'h000000E4}
   };
   localparam string TAGS [12] = '{"R1", "R1", "R7", "-", "R9", "-", "-",
                                   "R3", "-", "R8 R5", "-", "R10"};

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int n, l0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset pins
      check("R1 pins", {ready, pd_oe, n_write, n_astrb, n_dstrb}, 5'b11111);

      for (int i = 0; i < 12; i++) begin
         host(VEC[i][69], VEC[i][68:66], VEC[i][65:64], VEC[i][63:32], r, n);
         if (VEC[i][70]) check(TAGS[i], r, VEC[i][31:0]);
      end

      // R4 R8 R2: write log holds addr 3C, then EF, BE; blocked 0x11 absent
      check("R2 log count", log_n, 3);
      check("R4 addr byte", wlog[0], {1'b1, 8'h3C});
      check("R8 lane0", wlog[1], {1'b0, 8'hEF});
      check("R8 lane1", wlog[2], {1'b0, 8'hBE});

      // R10 reverse direction
      check("R10 oe off", pd_oe, 1'b0);
      host(0, 3'd0, 2'd0, 0, r, n);
      check("R10 data from pins", r, 32'h77);

      // R8 R5 four byte read
      host(0, 3'd4, 2'd2, 0, r, n);
      check("R8 wide read", r, 32'hA5A4A3A2);
      host(0, 3'd3, 2'd2, 0, r, n);
      check("R5 addr read", r, 32'hA6);

      // R9 skip equal writes
      host(1, 3'd2, 2'd0, 32'h04, r, n);
      check("R10 oe on", pd_oe, 1'b1);
      l0 = loads;
      host(1, 3'd0, 2'd0, 32'h55, r, n);
      check("R9 change load", loads - l0, 1);
      host(1, 3'd0, 2'd0, 32'h55, r, n);
      host(1, 3'd2, 2'd0, 32'h04, r, n);
      check("R9 equal skipped", loads - l0, 1);
      check("R9 pins hold", pd_out, 8'h55);

      // R6 timeout
      resp_en = 0;
      l0 = log_n;
      host(1, 3'd4, 2'd1, 32'h1234, r, n);
      check("R6 duration", (n >= TMO && n <= TMO + 6), 1);
      check("R6 strobe up", {n_dstrb, n_astrb}, 2'b11);
      host(0, 3'd1, 2'd0, 0, r, n);
      check("R6 flag set", r[0], 1'b1);
      resp_en = 1;

      // R7 clear semantics
      host(1, 3'd1, 2'd0, 32'h00, r, n);
      host(0, 3'd1, 2'd0, 0, r, n);
      check("R7 keep on zero", r, 32'h5B);
      host(1, 3'd1, 2'd0, 32'h01, r, n);
      host(0, 3'd1, 2'd0, 0, r, n);
      check("R7 cleared", r, 32'h5A);

      // R3 blocked reads in write mode
      host(0, 3'd4, 2'd2, 0, r, n);
      check("R3 wide ones", r, 32'hFFFFFFFF);
      host(0, 3'd3, 2'd0, 0, r, n);
      check("R3 addr ones", r, 32'hFF);
      check("R2 R3 no new bytes", log_n, l0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule